// File: doc/BRIEF.md
# Split-Window GPIO Controller with Edge Interrupts

This block is a memory-mapped controller for 32 general-purpose pins on a 16-bit register bus. Each 32-bit register is reached through two 16-bit windows. The low window covers bits 15:0, and the high window, 0x500 bytes above it, covers bits 31:16. The controller holds an output latch and an output-enable latch. It synchronises the input pins and watches them for level changes.

A pin that goes high while its rise-enable bit is set, or goes low while its fall-enable bit is set, sets its bit in a sticky status register. Software clears status bits by writing ones to them. The single interrupt line is high whenever any status bit is set.

Two fixed bits of the output latch are also driven on two dedicated wires for a software-driven two-wire serial bus. Those wires change only when the high output window is written.

Top module: `gpio_split`

## Requirements
- R1: In the reset cycle and the first cycle after it, every input synchroniser stage holds all ones. Therefore an input read issued in the first cycle after reset returns 0xFFFF. At reset, `pins_out`, `pins_oe`, `irq`, `ser_data`, `ser_clk` and all enable and status bits are 0.
- R2: A write to a low window (byte offsets: output enable 0x008, output 0x00C, fall enable 0x014, rise enable 0x018) loads bits 15:0 of that register from `wdata` and leaves bits 31:16 unchanged.
- R3: A write to a high window (the low offset plus 0x500) loads bits 31:16 from `wdata` and leaves bits 15:0 unchanged.
- R4: A read returns, one clock after `rd_en`, bits 15:0 of the register (low window) or bits 31:16 (high window) in `rdata`. The input register at 0x010/0x510 is read-only and ignores writes. Unmapped offsets read as 0.
- R5: When a pin's synchronised level rises with its rise-enable bit set, or falls with its fall-enable bit set, the pin's bit in the status register (0x020/0x520) is set.
- R6: A level change on a pin whose enable for that direction is clear leaves the status register unchanged.
- R7: `irq` equals the OR of all status bits, updated on the same clock edge as the status register.
- R8: Writing to a status window clears the bits written as one and keeps the bits written as zero. `irq` falls only after such a write.
- R9: If a clear of a status bit and a new qualifying edge on the same pin land on the same clock edge, the bit stays set.
- R10: `ser_data` follows output bit 29 and `ser_clk` follows output bit 30. Both change only on a write to the high output window, and a low output write has no effect on them.
- R11: `pins_out` always shows the output latch and `pins_oe` the output-enable latch.
- R12: A pin change applied between clock edges is visible in the input register after two edges. It sets status and `irq` on the third edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the register window |
| wdata | input | 16 | Write data for one half |
| rdata | output | 16 | Read data, registered, valid one clock after `rd_en` |
| pins_in | input | 32 | Asynchronous pin levels |
| pins_out | output | 32 | Output latch |
| pins_oe | output | 32 | Output-enable latch |
| irq | output | 1 | Interrupt, OR of status bits |
| ser_data | output | 1 | Serial data wire (output bit 29) |
| ser_clk | output | 1 | Serial clock wire (output bit 30) |

## Verification
Software clearing a status bit and the edge logic setting that same bit can meet on one clock edge. The bench provokes this by arming both edge enables on a pin, letting one edge set its status bit, and then flipping the pin again. It times a write-one-to-clear so that the write commits on exactly the third edge after the flip, which is the edge on which the new change is detected. Set-over-clear priority is judged by reading the status window back as still set and by seeing `irq` still high. A later clear with no edge pending must then drop both.

// File: rtl/gpio_split_pkg.sv
package gpio_split_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_OE   = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_OUT  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_IN   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_FEN  = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_REN  = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_STAT = 12'h020;
  localparam logic [ADDR_W-1:0] HI_STEP  = 12'h500;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_OE, SEL_OUT, SEL_IN, SEL_FEN, SEL_REN, SEL_STAT
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e sel;
    logic     hi;
  } dec_t;

  function automatic dec_t decode(input logic [ADDR_W-1:0] a);
    dec_t d;
    d.hi  = 1'b0;
    d.sel = SEL_NONE;
    if      (a == OFF_OE)             d.sel = SEL_OE;
    else if (a == OFF_OUT)            d.sel = SEL_OUT;
    else if (a == OFF_IN)             d.sel = SEL_IN;
    else if (a == OFF_FEN)            d.sel = SEL_FEN;
    else if (a == OFF_REN)            d.sel = SEL_REN;
    else if (a == OFF_STAT)           d.sel = SEL_STAT;
    else if (a == OFF_OE   + HI_STEP) begin d.sel = SEL_OE;   d.hi = 1'b1; end
    else if (a == OFF_OUT  + HI_STEP) begin d.sel = SEL_OUT;  d.hi = 1'b1; end
    else if (a == OFF_IN   + HI_STEP) begin d.sel = SEL_IN;   d.hi = 1'b1; end
    else if (a == OFF_FEN  + HI_STEP) begin d.sel = SEL_FEN;  d.hi = 1'b1; end
    else if (a == OFF_REN  + HI_STEP) begin d.sel = SEL_REN;  d.hi = 1'b1; end
    else if (a == OFF_STAT + HI_STEP) begin d.sel = SEL_STAT; d.hi = 1'b1; end
    return d;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= '1;
      else if (i == 0) st[i] <= d;
      else st[i] <= st[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else prev <= st[STAGES-1];
  end

  assign lvl = st[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
  parameter int HALF_W = 16,
  parameter int NREG   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG-1:0]   wr_lo,
  input  logic [NREG-1:0]   wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [2*HALF_W-1:0] q [NREG]
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q[r] <= '0;
      else begin
        if (wr_lo[r]) q[r][HALF_W-1:0]        <= wdata;
        if (wr_hi[r]) q[r][2*HALF_W-1:HALF_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] qual,
  output logic [W-1:0] stat,
  output logic         irq
);
  logic [W-1:0] stat_nx;

  assign qual    = (lvl & ~prev & rise_en) | (~lvl & prev & fall_en);
  assign stat_nx = (stat & ~clr_mask) | qual;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= stat_nx;
      irq  <= |stat_nx;
    end
  end
endmodule

// File: rtl/gpio_split.sv
module gpio_split
  import gpio_split_pkg::*;
#(
  parameter int HALF_W       = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int SER_DATA_BIT = 29,
  parameter int SER_CLK_BIT  = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [HALF_W-1:0]   wdata,
  output logic [HALF_W-1:0]   rdata,
  input  logic [2*HALF_W-1:0] pins_in,
  output logic [2*HALF_W-1:0] pins_out,
  output logic [2*HALF_W-1:0] pins_oe,
  output logic                irq,
  output logic                ser_data,
  output logic                ser_clk
);
  localparam int W      = 2*HALF_W;
  localparam int NREG   = 4;
  localparam int IX_OE  = 0;
  localparam int IX_OUT = 1;
  localparam int IX_FEN = 2;
  localparam int IX_REN = 3;

  dec_t dec;
  assign dec = decode(addr);

  logic [NREG-1:0] wr_bit, wr_lo, wr_hi;
  logic [W-1:0]    regq [NREG];
  logic [W-1:0]    lvl_w, prev_w, qual_w, stat_w, clr_w;

  always_comb begin
    wr_bit = '0;
    case (dec.sel)
      SEL_OE:  wr_bit[IX_OE]  = 1'b1;
      SEL_OUT: wr_bit[IX_OUT] = 1'b1;
      SEL_FEN: wr_bit[IX_FEN] = 1'b1;
      SEL_REN: wr_bit[IX_REN] = 1'b1;
      default: wr_bit = '0;
    endcase
  end

  assign wr_lo = (wr_en && !dec.hi) ? wr_bit : '0;
  assign wr_hi = (wr_en &&  dec.hi) ? wr_bit : '0;

  always_comb begin
    clr_w = '0;
    if (wr_en && dec.sel == SEL_STAT) begin
      if (dec.hi) clr_w[W-1:HALF_W] = wdata;
      else        clr_w[HALF_W-1:0] = wdata;
    end
  end

  gpio_regfile #(.HALF_W(HALF_W), .NREG(NREG)) u_regs (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(wdata), .q(regq)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pins_in), .lvl(lvl_w), .prev(prev_w)
  );

  gpio_edge #(.W(W)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl_w), .prev(prev_w),
    .rise_en(regq[IX_REN]), .fall_en(regq[IX_FEN]), .clr_mask(clr_w),
    .qual(qual_w), .stat(stat_w), .irq(irq)
  );

  logic [W-1:0] rd_full;
  always_comb begin
    case (dec.sel)
      SEL_OE:   rd_full = regq[IX_OE];
      SEL_OUT:  rd_full = regq[IX_OUT];
      SEL_IN:   rd_full = lvl_w;
      SEL_FEN:  rd_full = regq[IX_FEN];
      SEL_REN:  rd_full = regq[IX_REN];
      SEL_STAT: rd_full = stat_w;
      default:  rd_full = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= dec.hi ? rd_full[W-1:HALF_W] : rd_full[HALF_W-1:0];
    else            rdata <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_data <= 1'b0;
      ser_clk  <= 1'b0;
    end else if (wr_hi[IX_OUT]) begin
      ser_data <= wdata[SER_DATA_BIT-HALF_W];
      ser_clk  <= wdata[SER_CLK_BIT-HALF_W];
    end
  end

  assign pins_out = regq[IX_OUT];
  assign pins_oe  = regq[IX_OE];
endmodule

// File: rtl/gpio_split_chk.sv
module gpio_split_chk
  import gpio_split_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [2*HALF_W-1:0] pins_out,
  input logic                irq,
  input logic                ser_data,
  input logic                ser_clk,
  input logic [2*HALF_W-1:0] stat,
  input logic [2*HALF_W-1:0] qual
);
  localparam int W = 2*HALF_W;

  assert_irq_or_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (|stat));

  assert_lo_keeps_hi_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFF_OUT) |=> pins_out[W-1:HALF_W] == $past(pins_out[W-1:HALF_W]));

  assert_hi_keeps_lo_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFF_OUT + HI_STEP) |=> pins_out[HALF_W-1:0] == $past(pins_out[HALF_W-1:0]));

  assert_ser_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == OFF_OUT + HI_STEP) |=> $stable({ser_clk, ser_data}));

  assert_irq_fall_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(wr_en && (addr == OFF_STAT || addr == OFF_STAT + HI_STEP)));

  assert_status_needs_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (|(stat & ~$past(stat))) |-> $past(|qual));
endmodule

bind gpio_split gpio_split_chk #(.HALF_W(HALF_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .pins_out(pins_out),
  .irq(irq), .ser_data(ser_data), .ser_clk(ser_clk),
  .stat(stat_w), .qual(qual_w)
);

// File: tb/gpio_split_tb_top.sv
module gpio_split_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [31:0] pins_in = '0;
  logic [31:0] pins_out, pins_oe;
  logic        irq, ser_data, ser_clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  gpio_split dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pins_in(pins_in), .pins_out(pins_out),
    .pins_oe(pins_oe), .irq(irq), .ser_data(ser_data), .ser_clk(ser_clk)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops the expected read data and compares
  initial forever begin
    @(posedge clk);
    if (rd_en && !rst) begin
      logic [15:0] e;
      string t;
      @(negedge clk);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {16'h0, rdata}, {16'h0, e});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    rst = 1'b0;
    // first cycle after reset: synchroniser still all ones
    rd(12'h010, 16'hFFFF, "R1 input reads ones after reset");
    chk("R1 pins_out reset", pins_out, 32'h0);
    chk("R1 pins_oe reset", pins_oe, 32'h0);
    chk("R1 serial wires reset", {30'h0, ser_clk, ser_data}, 32'h0);
    edges(2);
    chk("R1 no irq after reset", {31'h0, irq}, 32'h0);

    // output latch halves
    wr(12'h00C, 16'h1234);
    chk("R2 low write", pins_out, 32'h0000_1234);
    wr(12'h50C, 16'hABCD);
    chk("R3 high write", pins_out, 32'hABCD_1234);
    chk("R10 ser from high write", {30'h0, ser_clk, ser_data}, 32'h1);
    wr(12'h00C, 16'h5678);
    chk("R2 low write keeps high", pins_out, 32'hABCD_5678);
    chk("R10 low write leaves ser", {30'h0, ser_clk, ser_data}, 32'h1);
    rd(12'h00C, 16'h5678, "R4 read output low");
    rd(12'h50C, 16'hABCD, "R4 read output high");
    wr(12'h50C, 16'h4000);
    chk("R10 clk high data low", {30'h0, ser_clk, ser_data}, 32'h2);
    chk("R11 pins_out", pins_out, 32'h4000_5678);

    wr(12'h008, 16'h00FF);
    wr(12'h508, 16'h8000);
    chk("R11 pins_oe", pins_oe, 32'h8000_00FF);
    rd(12'h508, 16'h8000, "R4 read oe high");
    rd(12'h004, 16'h0000, "R4 unmapped reads zero");

    // enables: rise on pins 0,1 ; fall on pin 16
    wr(12'h018, 16'h0003);
    wr(12'h514, 16'h0001);
    @(negedge clk); pins_in[0] = 1'b1;
    edges(3);
    chk("R5 rise sets irq", {31'h0, irq}, 32'h1);
    rd(12'h020, 16'h0001, "R5 status low after rise");
    @(negedge clk); pins_in[5] = 1'b1;
    edges(3);
    rd(12'h020, 16'h0001, "R6 unenabled pin ignored");
    @(negedge clk); pins_in[16] = 1'b1;
    edges(3);
    rd(12'h520, 16'h0000, "R6 rise on fall-only pin ignored");
    @(negedge clk); pins_in[16] = 1'b0;
    edges(3);
    rd(12'h520, 16'h0001, "R5 fall sets status high");

    wr(12'h020, 16'h0000);
    rd(12'h020, 16'h0001, "R8 zero write keeps status");
    wr(12'h520, 16'h0001);
    rd(12'h520, 16'h0000, "R8 high clear");
    chk("R7 irq held by remaining bit", {31'h0, irq}, 32'h1);
    wr(12'h020, 16'h0001);
    chk("R7 irq drops when empty", {31'h0, irq}, 32'h0);

    // latency on pin 1
    wr(12'h014, 16'h0002);
    @(negedge clk); pins_in[1] = 1'b1;
    edges(2);
    chk("R12 no irq after two edges", {31'h0, irq}, 32'h0);
    edges(1);
    chk("R12 irq on third edge", {31'h0, irq}, 32'h1);

    // collision: fall on pin 1 detected on the edge the clear commits
    @(negedge clk); pins_in[1] = 1'b0;
    @(negedge clk);
    wr(12'h020, 16'h0002);
    chk("R9 irq kept by set over clear", {31'h0, irq}, 32'h1);
    rd(12'h020, 16'h0002, "R9 status kept by set over clear");
    wr(12'h020, 16'h0002);
    chk("R8 clear with no edge", {31'h0, irq}, 32'h0);
    rd(12'h020, 16'h0000, "R8 status empty");

    rd(12'h010, 16'h0021, "R4 input low level");
    wr(12'h010, 16'h0000);
    rd(12'h010, 16'h0021, "R4 input ignores write");
    rd(12'h510, 16'h0000, "R4 input high level");

    edges(3);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4 reads pending actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule